// File: doc/BRIEF.md
# SMBus Bus Condition Analyzer

This block watches a two-wire SMBus segment next to a local controller and reports the state of the bus in four flags. It takes the levels the local controller intends to put on the clock and data wires. It also takes the levels read back from the shared open-drain wires, which have external pull-ups and so behave as a wired-AND. From the read-back levels it finds START and STOP conditions and reports whether the bus is busy. It also flags a clock wire that has been held low for too long.

Comparing the intended levels with the observed ones gives two more results. The first is whether the local controller still holds arbitration. The second is whether another device is stretching the clock. All four inputs are brought into the clock domain through the same two-stage synchronizer, so the intended and observed levels stay aligned.

Every time limit is computed from two parameters: the system clock frequency and the bus speed class. The bus-free delay after a STOP is one half period of the speed class. The inactivity limit is 50 µs. The low-clock timeout is 25 ms.

Top module: `smb_bus_monitor`

## Requirements
- R1: After a synchronous active-low reset, busy_o=0, timeout_o=0, arb_won_o=1 and stretch_o=0.
- R2: All four bus inputs pass through a two-flop synchronizer, so a flag responds on the third rising clock edge after an input changes.
- R3: A START, meaning the observed SDA falls while the observed SCL is high, sets busy_o to 1.
- R4: A STOP, meaning the observed SDA rises while the observed SCL is high, clears busy_o once both lines have stayed high for BUF = CLK_HZ/(2*CLASS_HZ) cycles. A START within that window keeps busy_o at 1.
- R5: busy_o also clears, with no STOP, after both observed lines have stayed high for IDLE = CLK_HZ/20000 consecutive cycles (50 µs).
- R6: timeout_o becomes 1 once the observed SCL has been low for more than TO = CLK_HZ/40 consecutive cycles (25 ms). It stays 1 after SCL returns high.
- R7: timeout_o returns to 0 at the next START.
- R8: arb_won_o falls to 0 when, while busy, the observed SCL rises with the controller's SDA at 1 and the observed SDA at 0.
- R9: The same SDA mismatch has no effect while the bus is not busy. A START sets arb_won_o back to 1.
- R10: stretch_o is 1 exactly while the controller's SCL is 1 and the observed SCL is 0, delayed as stated in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_scl_i | input | 1 | Clock level the local controller intends (1 = released) |
| bus_scl_i | input | 1 | Clock level read back from the bus wire |
| ctl_sda_i | input | 1 | Data level the local controller intends (1 = released) |
| bus_sda_i | input | 1 | Data level read back from the bus wire |
| busy_o | output | 1 | 1 while the bus is in use |
| timeout_o | output | 1 | 1 once a low-clock timeout has been seen |
| arb_won_o | output | 1 | 1 while arbitration is held, 0 once it is lost |
| stretch_o | output | 1 | 1 while another device holds the clock low |

## Verification
Some properties are checked on every clock cycle by assertions:
- a START is always followed by busy, a restored arbitration flag and a cleared timeout;
- a full idle count always clears busy;
- a timeout only rises after a low clock;
- arbitration is only lost while busy;
- stretching is only reported when the controller has released the clock.

The bench scenarios are needed to show the rest:
- the exact number of cycles to each flag change;
- a STOP that is cut short by a new START;
- an SDA mismatch that is ignored while the bus is idle;
- a timeout that persists after the clock is released.

// File: rtl/smb_mon_pkg.sv
// Shared types and threshold arithmetic for the SMBus bus analyzer.
// Assumes frequencies are given in Hz and that CLK_HZ is well above CLASS_HZ.
package smb_mon_pkg;

    // One synchronized sample of the four monitored levels.
    typedef struct packed {
        logic ctl_scl;
        logic line_scl;
        logic ctl_sda;
        logic line_sda;
    } smb_sample_t;

    // Cycles of both-lines-high that count as 50 us of inactivity.
    function automatic int unsigned idle_cycles(input int unsigned clk_hz);
        return (clk_hz / 20000 < 1) ? 1 : clk_hz / 20000;
    endfunction

    // Bus-free delay after STOP: one half period of the speed class.
    function automatic int unsigned buf_cycles(input int unsigned clk_hz,
                                               input int unsigned class_hz);
        return (clk_hz / (2 * class_hz) < 1) ? 1 : clk_hz / (2 * class_hz);
    endfunction

    // Cycles of low clock that make 25 ms.
    function automatic int unsigned timeout_cycles(input int unsigned clk_hz);
        return (clk_hz / 40 < 1) ? 1 : clk_hz / 40;
    endfunction

endpackage

// File: rtl/smb_sync.sv
// Two-stage synchronizer for a vector of asynchronous levels.
// Assumes each bit is independent; the reset value models idle (released) wires.
module smb_sync #(
    parameter int unsigned     W       = 4,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Shift the inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/smb_cond_detect.sv
// Finds START, STOP and rising clock edges on the synchronized bus lines.
// Assumes scl_i and sda_i are already in the clk domain.
module smb_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o
);
    logic scl_prev_q;
    logic sda_prev_q;

    // Keep last cycle's line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_i;
            sda_prev_q <= sda_i;
        end
    end

    // Decode conditions from the current and previous levels.
    always_comb begin
        start_o    = sda_prev_q && !sda_i && scl_i;
        stop_o     = !sda_prev_q && sda_i && scl_i;
        scl_rise_o = !scl_prev_q && scl_i;
    end
endmodule

// File: rtl/smb_busy_tracker.sv
// Holds the bus-busy flag: set by START, cleared after the bus-free delay
// following STOP or after a long stretch of both lines high.
// Assumes the inputs come from smb_cond_detect on the same synchronized lines.
module smb_busy_tracker #(
    parameter int unsigned IDLE_CYC = 600,
    parameter int unsigned BUF_CYC  = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic start_i,
    input  logic stop_i,
    output logic busy_o
);
    localparam int unsigned HMAX = (IDLE_CYC > BUF_CYC) ? IDLE_CYC : BUF_CYC;
    localparam int unsigned CW   = $clog2(HMAX + 1);
    localparam logic [CW-1:0] HMAX_L = CW'(HMAX);
    localparam logic [CW-1:0] IDLE_L = CW'(IDLE_CYC);
    localparam logic [CW-1:0] BUF_L  = CW'(BUF_CYC);

    logic [CW-1:0] high_cnt_q;
    logic          stop_pend_q;
    logic          busy_q;
    logic          release_now;

    // Busy ends after the bus-free delay past a STOP, or after inactivity.
    always_comb begin
        release_now = busy_q && ((stop_pend_q && high_cnt_q >= BUF_L) ||
                                 (high_cnt_q >= IDLE_L));
    end

    // Count consecutive cycles with both lines high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_cnt_q <= '0;
        end else if (scl_i && sda_i) begin
            if (high_cnt_q != HMAX_L) high_cnt_q <= high_cnt_q + 1'b1;
        end else begin
            high_cnt_q <= '0;
        end
    end

    // Track busy and whether a STOP has been seen since the last START.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            stop_pend_q <= 1'b0;
        end else if (start_i) begin
            busy_q      <= 1'b1;
            stop_pend_q <= 1'b0;
        end else if (release_now) begin
            busy_q      <= 1'b0;
            stop_pend_q <= 1'b0;
        end else if (stop_i) begin
            stop_pend_q <= 1'b1;
        end
    end

    assign busy_o = busy_q;

    // R3
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R5
    idle_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (high_cnt_q >= IDLE_L && !start_i) |=> !busy_o);
endmodule

// File: rtl/smb_timeout_timer.sv
// Raises a sticky timeout when the clock line stays low too long; a START clears it.
// Assumes scl_i is synchronized.
module smb_timeout_timer #(
    parameter int unsigned TO_CYC = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic start_i,
    output logic timeout_o
);
    localparam int unsigned CW = $clog2(TO_CYC + 1);
    localparam logic [CW-1:0] TO_L = CW'(TO_CYC);

    logic [CW-1:0] low_cnt_q;
    logic          timeout_q;

    // Count consecutive low clock cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (!scl_i) begin
            if (low_cnt_q != TO_L) low_cnt_q <= low_cnt_q + 1'b1;
        end else begin
            low_cnt_q <= '0;
        end
    end

    // Set the flag past the limit, hold it until a START.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_q <= 1'b0;
        end else if (start_i) begin
            timeout_q <= 1'b0;
        end else if (!scl_i && low_cnt_q == TO_L) begin
            timeout_q <= 1'b1;
        end
    end

    assign timeout_o = timeout_q;

    // R6
    timeout_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> $past(!scl_i));

    // R7
    start_clears_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !timeout_o);
endmodule

// File: rtl/smb_drive_compare.sv
// Compares the controller's intended levels with the observed wires to
// derive the arbitration and clock-stretching flags.
// Assumes intended and observed levels went through the same synchronizer.
module smb_drive_compare (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_scl_i,
    input  logic line_scl_i,
    input  logic ctl_sda_i,
    input  logic line_sda_i,
    input  logic scl_rise_i,
    input  logic start_i,
    input  logic busy_i,
    output logic arb_won_o,
    output logic stretch_o
);
    logic arb_q;
    logic stretch_q;
    logic sda_lost;

    // A released data bit read back low at a clock rise means another master won.
    always_comb begin
        sda_lost = busy_i && scl_rise_i && ctl_sda_i && !line_sda_i;
    end

    // Hold arbitration until lost, restore it at START.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q <= 1'b1;
        end else if (start_i) begin
            arb_q <= 1'b1;
        end else if (sda_lost) begin
            arb_q <= 1'b0;
        end
    end

    // Flag a released clock that another device keeps low.
    always_ff @(posedge clk) begin
        if (!rst_n) stretch_q <= 1'b0;
        else        stretch_q <= ctl_scl_i && !line_scl_i;
    end

    assign arb_won_o = arb_q;
    assign stretch_o = stretch_q;

    // R8
    arb_loss_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arb_won_o) |-> $past(busy_i));

    // R9
    start_restores_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> arb_won_o);

    // R10
    stretch_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_o |-> $past(ctl_scl_i));
endmodule

// File: rtl/smb_bus_monitor.sv
// Top of the SMBus bus analyzer: synchronizes the four levels, finds bus
// conditions, and reports busy, timeout, arbitration and stretching flags.
// Assumes open-drain wires with pull-ups; 1 on a controller input means released.
module smb_bus_monitor #(
    parameter int unsigned CLK_HZ   = 12_000_000,
    parameter int unsigned CLASS_HZ = 100_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_scl_i,
    input  logic bus_scl_i,
    input  logic ctl_sda_i,
    input  logic bus_sda_i,
    output logic busy_o,
    output logic timeout_o,
    output logic arb_won_o,
    output logic stretch_o
);
    import smb_mon_pkg::*;

    localparam int unsigned IDLE_CYC = idle_cycles(CLK_HZ);
    localparam int unsigned BUF_CYC  = buf_cycles(CLK_HZ, CLASS_HZ);
    localparam int unsigned TO_CYC   = timeout_cycles(CLK_HZ);
    localparam int unsigned SW       = $bits(smb_sample_t);

    smb_sample_t raw_s;
    smb_sample_t syn_s;
    logic        start_w;
    logic        stop_w;
    logic        rise_w;
    logic        busy_w;

    // Gather the four levels into one sample.
    always_comb begin
        raw_s.ctl_scl  = ctl_scl_i;
        raw_s.line_scl = bus_scl_i;
        raw_s.ctl_sda  = ctl_sda_i;
        raw_s.line_sda = bus_sda_i;
    end

    smb_sync #(.W(SW), .RST_VAL({SW{1'b1}})) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_s),
        .q_o   (syn_s)
    );

    smb_cond_detect u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (syn_s.line_scl),
        .sda_i      (syn_s.line_sda),
        .start_o    (start_w),
        .stop_o     (stop_w),
        .scl_rise_o (rise_w)
    );

    smb_busy_tracker #(.IDLE_CYC(IDLE_CYC), .BUF_CYC(BUF_CYC)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (syn_s.line_scl),
        .sda_i   (syn_s.line_sda),
        .start_i (start_w),
        .stop_i  (stop_w),
        .busy_o  (busy_w)
    );

    smb_timeout_timer #(.TO_CYC(TO_CYC)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (syn_s.line_scl),
        .start_i   (start_w),
        .timeout_o (timeout_o)
    );

    smb_drive_compare u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_scl_i  (syn_s.ctl_scl),
        .line_scl_i (syn_s.line_scl),
        .ctl_sda_i  (syn_s.ctl_sda),
        .line_sda_i (syn_s.line_sda),
        .scl_rise_i (rise_w),
        .start_i    (start_w),
        .busy_i     (busy_w),
        .arb_won_o  (arb_won_o),
        .stretch_o  (stretch_o)
    );

    assign busy_o = busy_w;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !timeout_o && arb_won_o && !stretch_o));
endmodule

// File: tb/smb_bus_monitor_tb.sv
// Bench for smb_bus_monitor: a behavioural reference model compared every
// clock, plus directed checks with hand-derived expected values.
module smb_bus_monitor_tb;
    localparam int unsigned CLK_HZ   = 1_000_000;
    localparam int unsigned CLASS_HZ = 100_000;
    localparam int BUF  = CLK_HZ / (2 * CLASS_HZ); // 5
    localparam int IDLE = CLK_HZ / 20000;          // 50
    localparam int TO   = CLK_HZ / 40;             // 25000
    localparam int HMAX = (IDLE > BUF) ? IDLE : BUF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cscl = 1'b1, lscl = 1'b1, csda = 1'b1, lsda = 1'b1;
    logic busy, tmo, arb, str;

    int n_checks = 0;
    int n_fail   = 0;
    bit armed    = 1'b0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    smb_bus_monitor #(.CLK_HZ(CLK_HZ), .CLASS_HZ(CLASS_HZ)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_scl_i (cscl),
        .bus_scl_i (lscl),
        .ctl_sda_i (csda),
        .bus_sda_i (lsda),
        .busy_o    (busy),
        .timeout_o (tmo),
        .arb_won_o (arb),
        .stretch_o (str)
    );

    // Reference model: input delay line held in a queue, behaviour in integers.
    logic [3:0] dq[$];
    int  m_hi, m_lo, m_pend;
    bit  m_busy, m_to, m_arb, m_st, pv_scl, pv_sda;

    always @(posedge clk) begin
        logic [3:0] s;
        bit st_c, sp_c, rs_c, rel;
        if (!rst_n) begin
            dq = {4'hF, 4'hF};
            m_hi = 0; m_lo = 0; m_pend = 0;
            m_busy = 0; m_to = 0; m_arb = 1; m_st = 0;
            pv_scl = 1; pv_sda = 1;
        end else begin
            s = dq[0];                      // {cscl, lscl, csda, lsda}
            st_c = pv_sda && !s[0] && s[2];
            sp_c = !pv_sda && s[0] && s[2];
            rs_c = !pv_scl && s[2];
            rel  = m_busy && ((m_pend != 0 && m_hi >= BUF) || m_hi >= IDLE);
            if (st_c || rs_c) begin end
            if (!(st_c == 1'b0 && m_busy && rs_c && s[1] && !s[0])) begin end
            if (st_c) m_arb = 1;
            else if (m_busy && rs_c && s[1] && !s[0]) m_arb = 0;
            if (st_c) begin m_busy = 1; m_pend = 0; end
            else if (rel) begin m_busy = 0; m_pend = 0; end
            else if (sp_c) m_pend = 1;
            if (st_c) m_to = 0;
            else if (!s[2] && m_lo == TO) m_to = 1;
            m_hi = (s[2] && s[0]) ? ((m_hi < HMAX) ? m_hi + 1 : m_hi) : 0;
            m_lo = (!s[2]) ? ((m_lo < TO) ? m_lo + 1 : m_lo) : 0;
            m_st = s[3] && !s[2];
            pv_scl = s[2]; pv_sda = s[0];
            void'(dq.pop_front());
            dq.push_back({cscl, lscl, csda, lsda});
        end
    end

    task automatic cmp(input string req, input string nm, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, nm, act, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            cmp("R4", "busy", busy, m_busy);
            cmp("R6", "timeout", tmo, m_to);
            cmp("R8", "arb", arb, m_arb);
            cmp("R10", "stretch", str, m_st);
        end
    end

    task automatic drv(input logic a, input logic b, input logic c, input logic d);
        cscl = a; lscl = b; csda = c; lsda = d;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        drv(1, 1, 1, 1);
        tick(4);
        // R1: reset values
        cmp("R1", "busy", busy, 1'b0);
        cmp("R1", "timeout", tmo, 1'b0);
        cmp("R1", "arb", arb, 1'b1);
        cmp("R1", "stretch", str, 1'b0);
        rst_n = 1'b1;
        armed = 1'b1;
        tick(2);

        // R2 and R10: stretch appears on the third edge
        drv(1, 0, 1, 1);
        tick(2);
        cmp("R2", "stretch", str, 1'b0);
        tick(1);
        cmp("R2", "stretch", str, 1'b1);
        drv(1, 1, 1, 1);
        tick(5);
        cmp("R10", "stretch", str, 1'b0);

        // R3: START
        drv(1, 1, 0, 0);
        tick(5);
        cmp("R3", "busy", busy, 1'b1);

        // R8: released data bit read back low at clock rise
        drv(0, 0, 0, 0); tick(3);
        drv(0, 0, 1, 0); tick(3);
        drv(1, 1, 1, 0); tick(5);
        cmp("R8", "arb", arb, 1'b0);

        // R4: STOP then bus-free delay
        drv(0, 0, 0, 0); tick(3);
        drv(1, 1, 0, 0); tick(3);
        drv(1, 1, 1, 1);
        tick(2 + BUF);
        cmp("R4", "busy", busy, 1'b1);
        tick(1);
        cmp("R4", "busy", busy, 1'b0);

        // R9: START restores arbitration
        drv(1, 1, 0, 0); tick(5);
        cmp("R9", "arb", arb, 1'b1);
        cmp("R3", "busy", busy, 1'b1);

        // R4: START inside the bus-free window keeps busy
        drv(1, 1, 1, 1); tick(3);
        drv(1, 1, 0, 0); tick(10);
        cmp("R4", "busy", busy, 1'b1);

        // R5: inactivity clears busy without STOP
        drv(0, 0, 0, 0); tick(3);
        drv(0, 0, 1, 1); tick(3);
        drv(1, 1, 1, 1);
        tick(IDLE);
        cmp("R5", "busy", busy, 1'b1);
        tick(10);
        cmp("R5", "busy", busy, 1'b0);

        // R9: mismatch ignored while idle
        drv(0, 0, 1, 1); tick(3);
        drv(0, 0, 1, 0); tick(3);
        drv(1, 1, 1, 0); tick(5);
        cmp("R9", "arb", arb, 1'b1);
        drv(1, 1, 1, 1); tick(5);

        // R6: long low clock
        drv(1, 1, 0, 0); tick(5);
        drv(0, 0, 0, 0);
        tick(TO - 10);
        cmp("R6", "timeout", tmo, 1'b0);
        tick(20);
        cmp("R6", "timeout", tmo, 1'b1);
        drv(1, 1, 0, 0); tick(10);
        cmp("R6", "timeout", tmo, 1'b1);

        // R7: next START clears timeout
        drv(1, 1, 1, 1); tick(3);
        drv(1, 1, 0, 0); tick(5);
        cmp("R7", "timeout", tmo, 1'b0);
        tick(5);
        finish_run();
    end
endmodule